// File: doc/BRIEF.md
# Legacy Idle-Level Read Redirector with Core Idle-State Resolver

This block serves one processor core. It watches the core's I/O read strobe. A read that lands on one of the legacy idle-level addresses inside a programmed window is taken off the external bus. In its place the block issues a native idle-state request: a target C-state, a substate, and a wake-on-interrupt flag. Reads outside the window, reads at unmapped offsets, and every read while redirection is disabled pass through as ordinary I/O.

The second half of the block resolves the core's idle state from the states requested by its hardware threads. The core can go no deeper than its shallowest thread. When the low-power C1 variant is enabled and the core settles at C1, it reports that variant. C-states are carried as an ordered 3-bit code: C0=0, C1=1, C3=2, C6=3, C7=4. With this code, resolution is a plain numeric minimum.

Top module: `idle_req_unit`

## Requirements
- R1: While `redir_en` is 0, every read strobe gives `io_pass`=1 and `io_trap`=0, and no request follows.
- R2: A trapped read at offset 2 from `lvl_base` requests code 2 (C3). Offset 3 requests code 3 (C6). Offset 4 or any higher trapped offset requests code 4 (C7).
- R3: A read is trapped only if its address is at or above `lvl_base` and its offset (address minus base, without wrap) is at most `lvl_limit`. Any other read passes through and produces no request.
- R4: In the cycle of a read strobe, exactly one of `io_trap` and `io_pass` is 1. Without a strobe, both are 0.
- R5: `req_valid` goes high in the cycle after a trapped read, for exactly one cycle. While it is high, `req_sub` is 0 and `req_brk` is 1.
- R6: A read at offset 0 or 1 inside the window passes through and produces no request.
- R7: One cycle after the thread codes are applied, `core_state` equals the minimum of the thread codes. Any thread code above 4 counts as 4.
- R8: `core_c1e` is 1 one cycle after the resolved state is C1 while `c1e_en` is 1. Otherwise it is 0.
- R9: During reset, `req_valid`, `core_state` and `core_c1e` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | I/O read strobe, one cycle per read |
| io_addr | input | ADDR_W | Address of the read |
| lvl_base | input | ADDR_W | Address of level offset 0 |
| lvl_limit | input | ADDR_W | Highest trapped offset from the base |
| redir_en | input | 1 | Enables redirection |
| thr_state | input | 3*NTHREADS | Requested C-state code per thread, thread 0 in the low bits |
| c1e_en | input | 1 | Enables the C1E report |
| io_trap | output | 1 | Read is trapped and kept off the bus (same cycle) |
| io_pass | output | 1 | Read goes to the bus as normal I/O (same cycle) |
| req_valid | output | 1 | One-cycle pulse carrying a converted request |
| req_state | output | 3 | Requested C-state code |
| req_sub | output | SUB_W | Requested substate, always 0 |
| req_brk | output | 1 | Wake on interrupt even when interrupts are masked |
| core_state | output | 3 | Resolved core C-state code |
| core_c1e | output | 1 | Core reports C1E instead of C1 |

## Verification
The bench builds the block with ADDR_W=16, SUB_W=4 and NTHREADS=2. The 16-bit address lets a window be placed right below the top of the address space, which exercises the no-wrap offset rule at the wrap point. Two threads with 3-bit codes give 64 pairings, including the out-of-range codes 5 to 7. All 64 are swept with C1E both off and on. Address sweeps cover both window edges and the unmapped offsets 0 and 1, and they are mixed with seeded random reads against random windows.

// File: rtl/idle_req_pkg.sv
package idle_req_pkg;

    localparam int CS_W = 3;

    typedef enum logic [CS_W-1:0] {
        CS_C0 = 3'd0,
        CS_C1 = 3'd1,
        CS_C3 = 3'd2,
        CS_C6 = 3'd3,
        CS_C7 = 3'd4
    } cstate_e;

    typedef struct packed {
        logic    valid;
        cstate_e state;
        logic    brk;
    } idle_req_t;

    // Codes past the deepest state are treated as the deepest state.
    function automatic cstate_e clamp_cs(logic [CS_W-1:0] c);
        return (c > 3'd4) ? CS_C7 : cstate_e'(c);
    endfunction

    // Level offset 2 -> C3, 3 -> C6, anything deeper -> C7.
    function automatic cstate_e lvl_map(logic is_two, logic is_three);
        if (is_two)   return CS_C3;
        if (is_three) return CS_C6;
        return CS_C7;
    endfunction

endpackage

// File: rtl/lvl_trap.sv
module lvl_trap
    import idle_req_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SUB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [ADDR_W-1:0] lvl_base,
    input  logic [ADDR_W-1:0] lvl_limit,
    input  logic              redir_en,
    output logic              io_trap,
    output logic              io_pass,
    output logic              req_valid,
    output logic [CS_W-1:0]   req_state,
    output logic [SUB_W-1:0]  req_sub,
    output logic              req_brk
);

    localparam int DIFF_W = ADDR_W + 1;

    logic [DIFF_W-1:0] diff;
    logic [ADDR_W-1:0] offset;
    logic              below_base;
    logic              in_window;
    logic              mapped;
    logic              hit;
    idle_req_t         req_d;
    idle_req_t         req_q;

    // Extra bit catches addresses under the base instead of letting them wrap.
    assign diff       = {1'b0, io_addr} - {1'b0, lvl_base};
    assign below_base = diff[DIFF_W-1];
    assign offset     = diff[ADDR_W-1:0];
    assign in_window  = !below_base && (offset <= lvl_limit);
    assign mapped     = offset >= ADDR_W'(2);
    assign hit        = io_rd && redir_en && in_window && mapped;

    assign io_trap = hit;
    assign io_pass = io_rd && !hit;

    always_comb begin
        req_d.valid = hit;
        req_d.state = lvl_map(offset == ADDR_W'(2), offset == ADDR_W'(3));
        req_d.brk   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{valid: 1'b0, state: CS_C0, brk: 1'b0};
        end else begin
            req_q.valid <= req_d.valid;
            if (req_d.valid) begin
                req_q.state <= req_d.state;
                req_q.brk   <= req_d.brk;
            end
        end
    end

    assign req_valid = req_q.valid;
    assign req_state = req_q.state;
    assign req_sub   = '0;
    assign req_brk   = req_q.brk;

endmodule

// File: rtl/core_resolve.sv
module core_resolve
    import idle_req_pkg::*;
#(
    parameter int NTHREADS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NTHREADS*CS_W-1:0] thr_state,
    input  logic                     c1e_en,
    output logic [CS_W-1:0]          core_state,
    output logic                     core_c1e
);

    logic [CS_W-1:0] chain [NTHREADS+1];
    logic [CS_W-1:0] core_q;
    logic            c1e_q;

    assign chain[0] = CS_C7;

    for (genvar g = 0; g < NTHREADS; g++) begin : g_min
        logic [CS_W-1:0] cl;
        assign cl         = clamp_cs(thr_state[g*CS_W +: CS_W]);
        assign chain[g+1] = (cl < chain[g]) ? cl : chain[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= CS_C0;
            c1e_q  <= 1'b0;
        end else begin
            core_q <= chain[NTHREADS];
            c1e_q  <= c1e_en && (chain[NTHREADS] == CS_C1);
        end
    end

    assign core_state = core_q;
    assign core_c1e   = c1e_q;

endmodule

// File: rtl/idle_req_unit.sv
module idle_req_unit
    import idle_req_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SUB_W    = 4,
    parameter int NTHREADS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     io_rd,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic [ADDR_W-1:0]        lvl_base,
    input  logic [ADDR_W-1:0]        lvl_limit,
    input  logic                     redir_en,
    input  logic [NTHREADS*CS_W-1:0] thr_state,
    input  logic                     c1e_en,
    output logic                     io_trap,
    output logic                     io_pass,
    output logic                     req_valid,
    output logic [CS_W-1:0]          req_state,
    output logic [SUB_W-1:0]         req_sub,
    output logic                     req_brk,
    output logic [CS_W-1:0]          core_state,
    output logic                     core_c1e
);

    lvl_trap #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_trap (
        .clk       (clk),
        .rst       (rst),
        .io_rd     (io_rd),
        .io_addr   (io_addr),
        .lvl_base  (lvl_base),
        .lvl_limit (lvl_limit),
        .redir_en  (redir_en),
        .io_trap   (io_trap),
        .io_pass   (io_pass),
        .req_valid (req_valid),
        .req_state (req_state),
        .req_sub   (req_sub),
        .req_brk   (req_brk)
    );

    core_resolve #(.NTHREADS(NTHREADS)) u_res (
        .clk        (clk),
        .rst        (rst),
        .thr_state  (thr_state),
        .c1e_en     (c1e_en),
        .core_state (core_state),
        .core_c1e   (core_c1e)
    );

endmodule

// File: rtl/idle_req_unit_chk.sv
module idle_req_unit_chk
    import idle_req_pkg::*;
#(
    parameter int SUB_W    = 4,
    parameter int NTHREADS = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     io_rd,
    input logic                     redir_en,
    input logic                     io_trap,
    input logic                     io_pass,
    input logic                     req_valid,
    input logic [CS_W-1:0]          req_state,
    input logic [SUB_W-1:0]         req_sub,
    input logic                     req_brk,
    input logic [NTHREADS*CS_W-1:0] thr_state,
    input logic [CS_W-1:0]          core_state,
    input logic                     core_c1e
);

    a_r1_no_trap_when_off: assert property (@(posedge clk) disable iff (rst)
        !redir_en |-> !io_trap);

    a_r2_deep_target: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_state >= CS_C3 && req_state <= CS_C7));

    a_r4_one_path: assert property (@(posedge clk) disable iff (rst)
        io_rd |-> (io_trap != io_pass));

    a_r4_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (!io_trap && !io_pass));

    a_r5_follows_trap: assert property (@(posedge clk) disable iff (rst)
        io_trap |=> req_valid);

    a_r5_only_after_trap: assert property (@(posedge clk) disable iff (rst)
        !io_trap |=> !req_valid);

    a_r5_fixed_fields: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_sub == '0 && req_brk));

    a_r8_c1e_at_c1: assert property (@(posedge clk) disable iff (rst)
        core_c1e |-> (core_state == CS_C1));

    for (genvar g = 0; g < NTHREADS; g++) begin : g_thr
        a_r7_not_deeper: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (core_state <= clamp_cs($past(thr_state[g*CS_W +: CS_W]))));
    end

endmodule

bind idle_req_unit idle_req_unit_chk #(.SUB_W(SUB_W), .NTHREADS(NTHREADS)) u_chk (.*);

// File: tb/idle_req_unit_tb.sv
`timescale 1ns/1ps
module idle_req_unit_tb;

    localparam int AW = 16;
    localparam int SW = 4;
    localparam int NT = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            io_rd = 1'b0;
    logic [AW-1:0]   io_addr = '0;
    logic [AW-1:0]   lvl_base = '0;
    logic [AW-1:0]   lvl_limit = '0;
    logic            redir_en = 1'b0;
    logic [NT*3-1:0] thr_state = '0;
    logic            c1e_en = 1'b0;
    logic            io_trap, io_pass, req_valid, req_brk, core_c1e;
    logic [2:0]      req_state, core_state;
    logic [SW-1:0]   req_sub;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    idle_req_unit #(.ADDR_W(AW), .SUB_W(SW), .NTHREADS(NT)) u_dut (
        .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr),
        .lvl_base(lvl_base), .lvl_limit(lvl_limit), .redir_en(redir_en),
        .thr_state(thr_state), .c1e_en(c1e_en), .io_trap(io_trap),
        .io_pass(io_pass), .req_valid(req_valid), .req_state(req_state),
        .req_sub(req_sub), .req_brk(req_brk), .core_state(core_state),
        .core_c1e(core_c1e)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int offs(logic [AW-1:0] a, logic [AW-1:0] b);
        return int'(a) - int'(b);
    endfunction

    function automatic bit exp_hit(logic [AW-1:0] a);
        int o = offs(a, lvl_base);
        return redir_en && o >= 2 && o <= int'(lvl_limit);
    endfunction

    function automatic int exp_cs(logic [AW-1:0] a);
        int o = offs(a, lvl_base);
        if (o == 2) return 2;
        if (o == 3) return 3;
        return 4;
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        int o = offs(a, lvl_base);
        if (!redir_en) return "R1";
        if (o < 0 || o > int'(lvl_limit)) return "R3";
        if (o < 2) return "R6";
        return "R2";
    endfunction

    function automatic int clampc(logic [2:0] c);
        return (c > 3'd4) ? 4 : int'(c);
    endfunction

    task automatic do_read(logic [AW-1:0] a);
        bit    h;
        string t;
        @(negedge clk);
        io_rd = 1'b1;
        io_addr = a;
        #1;
        h = exp_hit(a);
        t = tag_of(a);
        check({t, " R4 io_trap"}, 32'(io_trap), 32'(h));
        check({t, " R4 io_pass"}, 32'(io_pass), 32'(!h));
        @(negedge clk);
        io_rd = 1'b0;
        #1;
        check({t, " R4 idle trap"}, 32'(io_trap | io_pass), 32'd0);
        check({t, " R5 req_valid"}, 32'(req_valid), 32'(h));
        if (h) begin
            check("R2 req_state", 32'(req_state), 32'(exp_cs(a)));
            check("R5 req_sub", 32'(req_sub), 32'd0);
            check("R5 req_brk", 32'(req_brk), 32'd1);
        end
        @(negedge clk);
        check("R5 pulse ends", 32'(req_valid), 32'd0);
    endtask

    task automatic set_thr(logic [2:0] t0, logic [2:0] t1, logic en);
        int m;
        @(negedge clk);
        thr_state = {t1, t0};
        c1e_en = en;
        m = (clampc(t0) < clampc(t1)) ? clampc(t0) : clampc(t1);
        @(negedge clk);
        check("R7 core_state", 32'(core_state), 32'(m));
        check("R8 core_c1e", 32'(core_c1e), 32'(en && m == 1));
    endtask

    task automatic sweep(logic [AW-1:0] b, logic [AW-1:0] l);
        lvl_base = b;
        lvl_limit = l;
        for (int d = -3; d <= int'(l) + 3; d++) begin
            do_read(AW'(int'(b) + d));
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        io_rd = 1'b1;
        io_addr = 16'h0412;
        redir_en = 1'b1;
        lvl_base = 16'h0410;
        lvl_limit = 16'd7;
        thr_state = 6'o44;
        c1e_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset req_valid", 32'(req_valid), 32'd0);
        check("R9 reset core_state", 32'(core_state), 32'd0);
        check("R9 reset core_c1e", 32'(core_c1e), 32'd0);
        io_rd = 1'b0;
        rst = 1'b0;

        // R1: redirection off
        redir_en = 1'b0;
        sweep(16'h0410, 16'd7);
        // R2 R3 R6: window edges
        redir_en = 1'b1;
        sweep(16'h0410, 16'd7);
        sweep(16'h0000, 16'd5);
        sweep(16'h0800, 16'd0);
        sweep(16'h0800, 16'd2);
        sweep(16'hFFFA, 16'd12);

        // Random windows and reads
        for (int i = 0; i < 400; i++) begin
            redir_en = ($urandom_range(0, 7) != 0);
            lvl_base = AW'($urandom_range(0, 16'hFFFF));
            lvl_limit = AW'($urandom_range(0, 9));
            do_read(AW'(int'(lvl_base) + $urandom_range(0, 14) - 3));
        end

        // R7 R8: every thread pairing, C1E off and on
        for (int e = 0; e < 2; e++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    set_thr(3'(a), 3'(b), 1'(e));
                end
            end
        end
        for (int i = 0; i < 100; i++) begin
            set_thr(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                    1'($urandom_range(0, 1)));
        end

        finish_run();
    end

endmodule